// File: doc/BRIEF.md
# Stoppable Global Cycle Counter with Compare and Local Interrupt Routing

This block holds a global cycle counter whose implemented width is set by a parameter, in 4-bit steps above 32 bits. A stop bit in the configuration word freezes the counter. Clearing the bit lets it resume from the value it held. Software on a 32-bit register port reads the counter as two 32-bit halves. Because the upper half changes rarely, a high-low-high read sequence gives a value that is not torn between the halves.

A 64-bit compare value is written and read back as two 32-bit halves. When the counter equals the compare value, a sticky timer pending flag is set. Writing either compare half clears the flag. The block also gathers six local interrupt sources: the timer, three level inputs (performance counter, watchdog, debug channel) and two software-set bits. A mask with set-bit and clear-bit write ports gates these sources. Each source has a route word holding an enable bit and a pin number, which steers the source to one of the interrupt output pins.

The register port is a plain word-addressed interface. Writes take effect at the next clock edge and reads return data combinationally.

Top module: `gtimer_irq_unit`

## Requirements
- R1: The config word (address 0) holds the stop bit at bit 0, which is read/write. It holds the read-only count-width field CNT_NIB at bits 7:4. The counter width is 32 + 4 × CNT_NIB bits. All other bits read 0, and writes to the field are ignored.
- R2: While the stop bit is 1, the counter holds its value.
- R3: While the stop bit is 0, the counter increases by one on every clock and resumes from the value it held. It wraps at its implemented width.
- R4: Counter bits 31:0 read at address 1 and bits 63:32 read at address 2. Bits above the implemented width read 0.
- R5: The compare value is written and read back as a low half (address 3) and a high half (address 4).
- R6: The timer pending flag (pending bit 0) sets on the clock edge at which the counter equals the compare value, and stays set afterwards.
- R7: A write to either compare half clears the timer pending flag. The write wins over a match in the same cycle.
- R8: The pending word (address 5) is laid out as follows: bit 0 is the timer, bits 1, 2 and 3 are the levels of ext_src[0], ext_src[1] and ext_src[2], and bits 4 and 5 are software sources 0 and 1.
- R9: Writing ones to address 9 sets software pending bits [1:0] (mapping to pending bits 4 and 5). Writing ones to address 10 clears them.
- R10: The mask reads at address 6. A write to address 7 sets the mask bits written as one, and a write to address 8 clears them. Only bits 5:0 exist, and higher written bits are ignored.
- R11: Route word for source s is at address 16+s. Bit 31 is the enable, bits 2:0 are the pin number, and other bits read 0.
- R12: irq_pin[p] is 1 exactly when some source is pending, unmasked and enabled, and routed to pin p. A pin number of NPIN or higher drives no pin.
- R13: Reset leaves the block in this state: counter 0, stop 0, mask 0, software and timer pending 0, route words 0, and compare all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_src | input | 3 | Level sources: performance counter, watchdog, debug channel |
| irq_pin | output | 6 | Routed interrupt outputs |

## Verification
The assertions assume that one word is addressed per cycle. As a result, a mask set and a mask clear, or a compare write and another register write, never occur in the same cycle. They also assume that ext_src is synchronous to clk. The stimulus drives every input on the falling edge and issues writes strictly one at a time. Before it places a compare value ahead of the counter, it stops the counter, so a match is reached on a predictable edge rather than by chance.

// File: rtl/gtu_pkg.sv
// Shared constants: word addresses and local source indices.
package gtu_pkg;
    localparam int ADDR_W = 6;
    localparam int NSRC   = 6;

    localparam logic [ADDR_W-1:0] A_CFG    = 6'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 6'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 6'd2;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 6'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 6'd4;
    localparam logic [ADDR_W-1:0] A_PEND   = 6'd5;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'd6;
    localparam logic [ADDR_W-1:0] A_MSET   = 6'd7;
    localparam logic [ADDR_W-1:0] A_MCLR   = 6'd8;
    localparam logic [ADDR_W-1:0] A_SWSET  = 6'd9;
    localparam logic [ADDR_W-1:0] A_SWCLR  = 6'd10;
    localparam logic [ADDR_W-1:0] A_MAP0   = 6'd16;

    localparam int S_TIMER = 0;
    localparam int S_SW0   = 4;
endpackage

// File: rtl/gtu_counter.sv
// Global cycle counter with a stop control.
// Assumes CNT_NIB in 0..8, so that the width stays within 64 bits.
module gtu_counter #(
    parameter int CNT_NIB = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_we,
    input  logic        stop_wdata,
    output logic        stop,
    output logic [63:0] cnt64
);
    localparam int CW = 32 + 4 * CNT_NIB;

    logic [CW-1:0] cnt;

    // Stop bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)       stop <= 1'b0;
        else if (stop_we) stop <= stop_wdata;
    end

    // Count up by one on every clock while not stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!stop) cnt <= cnt + CW'(1);
    end

    assign cnt64 = 64'(cnt);

    a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(cnt));
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/gtu_compare.sv
// 64-bit compare register and sticky timer pending flag.
// Assumes the two half writes are never issued in the same cycle.
module gtu_compare (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic [63:0] cnt64,
    output logic [63:0] cmp64,
    output logic        tpend
);
    logic cmp_wr;
    assign cmp_wr = wr_lo | wr_hi;

    // Compare halves; reset to all ones so no match occurs at start.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp64 <= '1;
        else begin
            if (wr_lo) cmp64[31:0]  <= wdata;
            if (wr_hi) cmp64[63:32] <= wdata;
        end
    end

    // Timer pending: a compare write clears it, otherwise a match sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                tpend <= 1'b0;
        else if (cmp_wr)           tpend <= 1'b0;
        else if (cnt64 == cmp64)   tpend <= 1'b1;
    end

    a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt64 == cmp64 && !cmp_wr) |=> tpend);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tpend && !cmp_wr) |=> tpend);
    a_r7_cmp_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !tpend);
endmodule

// File: rtl/gtu_local.sv
// Local interrupt sources, mask, software pending bits and pin routing.
// Assumes at most one of the write strobes is active in any cycle.
module gtu_local
    import gtu_pkg::*;
#(
    parameter int NPIN = 6,
    parameter int PINW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mset_we,
    input  logic                      mclr_we,
    input  logic                      swset_we,
    input  logic                      swclr_we,
    input  logic                      map_we,
    input  logic [2:0]                map_sel,
    input  logic [NSRC-1:0]           wd_bits,
    input  logic                      wd_en,
    input  logic [PINW-1:0]           wd_pin,
    input  logic                      tpend,
    input  logic [2:0]                ext_src,
    output logic [NSRC-1:0]           pend,
    output logic [NSRC-1:0]           mask,
    output logic [NSRC-1:0]           map_en,
    output logic [NSRC-1:0][PINW-1:0] map_pin,
    output logic [NPIN-1:0]           irq_pin
);
    logic [1:0]      sw;
    logic [NSRC-1:0] active;

    // Mask register with set and clear write ports.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mset_we) mask <= mask | wd_bits;
        else if (mclr_we) mask <= mask & ~wd_bits;
    end

    // Software pending bits with set and clear write ports.
    always_ff @(posedge clk) begin
        if (!rst_n)        sw <= '0;
        else if (swset_we) sw <= sw | wd_bits[1:0];
        else if (swclr_we) sw <= sw & ~wd_bits[1:0];
    end

    // One route word per source.
    for (genvar s = 0; s < NSRC; s++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_en[s]  <= 1'b0;
                map_pin[s] <= '0;
            end else if (map_we && map_sel == 3'(s)) begin
                map_en[s]  <= wd_en;
                map_pin[s] <= wd_pin;
            end
        end
    end

    assign pend   = {sw, ext_src, tpend};
    assign active = pend & mask & map_en;

    // Drive each pin from the sources routed to it.
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [NSRC-1:0] hit;
        for (genvar s = 0; s < NSRC; s++) begin : g_hit
            assign hit[s] = (map_pin[s] == PINW'(p));
        end
        assign irq_pin[p] = |(active & hit);
    end

    a_r10_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        mset_we |=> (mask & $past(wd_bits)) == $past(wd_bits));
    a_r10_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_we |=> (mask & $past(wd_bits)) == '0);
    a_r9_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        swset_we |=> (sw & $past(wd_bits[1:0])) == $past(wd_bits[1:0]));
    a_r12_pin_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin != '0) |-> ((pend & mask) != '0));
endmodule

// File: rtl/gtimer_irq_unit.sv
// Top level: register decode and read mux over the counter, the compare
// register and the local interrupt logic.
// Assumes one word access per cycle and ext_src synchronous to clk.
module gtimer_irq_unit
    import gtu_pkg::*;
#(
    parameter int CNT_NIB = 8,
    parameter int NPIN    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [2:0]        ext_src,
    output logic [NPIN-1:0]   irq_pin
);
    localparam int PINW = (NPIN > 1) ? $clog2(NPIN + 1) : 1;

    logic                      stop;
    logic [63:0]               cnt64, cmp64;
    logic                      tpend;
    logic [NSRC-1:0]           pend, mask, map_en;
    logic [NSRC-1:0][PINW-1:0] map_pin;
    logic                      in_map;
    logic [2:0]                map_idx;

    assign map_idx = bus_addr[2:0];
    assign in_map  = (bus_addr[ADDR_W-1:3] == A_MAP0[ADDR_W-1:3]) && (int'(map_idx) < NSRC);

    gtu_counter #(.CNT_NIB(CNT_NIB)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .stop_we(bus_we && bus_addr == A_CFG), .stop_wdata(bus_wdata[0]),
        .stop(stop), .cnt64(cnt64)
    );

    gtu_compare u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(bus_we && bus_addr == A_CMP_LO),
        .wr_hi(bus_we && bus_addr == A_CMP_HI),
        .wdata(bus_wdata), .cnt64(cnt64), .cmp64(cmp64), .tpend(tpend)
    );

    gtu_local #(.NPIN(NPIN), .PINW(PINW)) u_loc (
        .clk(clk), .rst_n(rst_n),
        .mset_we(bus_we && bus_addr == A_MSET),
        .mclr_we(bus_we && bus_addr == A_MCLR),
        .swset_we(bus_we && bus_addr == A_SWSET),
        .swclr_we(bus_we && bus_addr == A_SWCLR),
        .map_we(bus_we && in_map), .map_sel(map_idx),
        .wd_bits(bus_wdata[NSRC-1:0]), .wd_en(bus_wdata[31]),
        .wd_pin(bus_wdata[PINW-1:0]),
        .tpend(tpend), .ext_src(ext_src),
        .pend(pend), .mask(mask), .map_en(map_en), .map_pin(map_pin),
        .irq_pin(irq_pin)
    );

    // Read mux; unassigned addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            bus_rdata = 32'(map_pin[map_idx]);
            bus_rdata[31] = map_en[map_idx];
        end else begin
            case (bus_addr)
                A_CFG:    bus_rdata = {24'b0, 4'(CNT_NIB), 3'b0, stop};
                A_CNT_LO: bus_rdata = cnt64[31:0];
                A_CNT_HI: bus_rdata = cnt64[63:32];
                A_CMP_LO: bus_rdata = cmp64[31:0];
                A_CMP_HI: bus_rdata = cmp64[63:32];
                A_PEND:   bus_rdata = 32'(pend);
                A_MASK:   bus_rdata = 32'(mask);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: tb/sim_gtimer_irq_unit.sv
module sim_gtimer_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ext_src = '0;
    logic [5:0]  irq_pin;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    gtimer_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_src(ext_src), .irq_pin(irq_pin)
    );

    // Vector: {we, addr, data}; for reads, data is the expected value.
    localparam int NV = 30;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 6'd0,  32'h0000_0080},  // R1 width field
        {1'b1, 6'd0,  32'h0000_00F0},  // R1 field write ignored
        {1'b0, 6'd0,  32'h0000_0080},  // R1
        {1'b0, 6'd6,  32'h0000_0000},  // R13 mask reset
        {1'b1, 6'd7,  32'h0000_0015},  // R10 set
        {1'b0, 6'd6,  32'h0000_0015},  // R10
        {1'b1, 6'd8,  32'h0000_0005},  // R10 clear
        {1'b0, 6'd6,  32'h0000_0010},  // R10
        {1'b1, 6'd7,  32'hFFFF_FFC0},  // R10 high bits ignored
        {1'b0, 6'd6,  32'h0000_0010},  // R10
        {1'b1, 6'd8,  32'h0000_003F},  // R10
        {1'b0, 6'd6,  32'h0000_0000},  // R10
        {1'b0, 6'd3,  32'hFFFF_FFFF},  // R13 compare reset
        {1'b0, 6'd4,  32'hFFFF_FFFF},  // R13
        {1'b1, 6'd4,  32'h1234_5678},  // R5
        {1'b0, 6'd4,  32'h1234_5678},  // R5
        {1'b1, 6'd3,  32'h9ABC_DEF0},  // R5
        {1'b0, 6'd3,  32'h9ABC_DEF0},  // R5
        {1'b0, 6'd5,  32'h0000_0000},  // R8
        {1'b1, 6'd9,  32'h0000_0003},  // R9 set both
        {1'b0, 6'd5,  32'h0000_0030},  // R9 bits 4,5
        {1'b1, 6'd10, 32'h0000_0001},  // R9 clear sw0
        {1'b0, 6'd5,  32'h0000_0020},  // R9
        {1'b1, 6'd10, 32'h0000_0002},  // R9
        {1'b0, 6'd5,  32'h0000_0000},  // R9
        {1'b0, 6'd17, 32'h0000_0000},  // R13 route reset
        {1'b1, 6'd17, 32'hFFFF_FFFF},  // R11
        {1'b0, 6'd17, 32'h8000_0007},  // R11 only enable and pin
        {1'b1, 6'd17, 32'h0000_0005},  // R11
        {1'b0, 6'd17, 32'h0000_0005}   // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] a, b, h;
        // R13: state while in reset
        repeat (3) @(negedge clk);
        rd(6'd1, a); chk("R13 counter in reset", a, 0);
        rd(6'd0, a); chk("R13 config in reset", a, 32'h80);
        chk("R13 pins in reset", 32'(irq_pin), 0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][38]) wr(VEC[i][37:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][37:32], a);
                chk($sformatf("table row %0d", i), a, VEC[i][31:0]);
            end
        end

        // R3: free running step
        @(negedge clk); rd(6'd1, a);
        repeat (3) @(negedge clk);
        rd(6'd1, b); chk("R3 three cycles", b - a, 3);

        // R2, R4: stopped counter holds, high half zero
        wr(6'd0, 1);
        rd(6'd1, h);
        repeat (5) @(negedge clk);
        rd(6'd1, b); chk("R2 held", b, h);
        rd(6'd2, b); chk("R4 high half", b, 0);
        rd(6'd0, b); chk("R1 stop bit readback", b, 32'h81);

        // R3: resume from held value
        wr(6'd0, 0);
        rd(6'd1, a); chk("R3 resume value", a, h);
        @(negedge clk);
        rd(6'd1, b); chk("R3 resume step", b, h + 1);

        // R6, R7: compare match
        wr(6'd0, 1);
        rd(6'd1, h);
        wr(6'd4, 0);
        wr(6'd3, h + 4);
        rd(6'd5, a); chk("R6 no early match", a & 1, 0);
        wr(6'd0, 0);
        repeat (4) @(negedge clk);
        rd(6'd5, a); chk("R6 not before edge", a & 1, 0);
        @(negedge clk);
        rd(6'd5, a); chk("R6 match sets", a & 1, 1);
        repeat (4) @(negedge clk);
        rd(6'd5, a); chk("R6 sticky", a & 1, 1);
        wr(6'd3, 32'hFFFF_FFFF);
        rd(6'd5, a); chk("R7 write clears", a & 1, 0);

        // R8, R12: routing
        ext_src = 3'b010;
        @(negedge clk);
        rd(6'd5, a); chk("R8 watchdog bit", a, 32'h4);
        chk("R12 masked", 32'(irq_pin), 0);
        wr(6'd7, 32'h4);
        chk("R12 route disabled", 32'(irq_pin), 0);
        wr(6'd18, 32'h8000_0005);
        chk("R12 pin 5", 32'(irq_pin), 32'h20);
        wr(6'd18, 32'h8000_0007);
        chk("R12 pin out of range", 32'(irq_pin), 0);
        wr(6'd18, 32'h8000_0000);
        chk("R12 pin 0", 32'(irq_pin), 32'h1);
        wr(6'd8, 32'h4);
        chk("R12 mask cleared", 32'(irq_pin), 0);
        wr(6'd9, 32'h1);
        wr(6'd7, 32'h10);
        wr(6'd20, 32'h8000_0003);
        chk("R12 software to pin 3", 32'(irq_pin), 32'h8);

        // R13: reset again
        ext_src = 3'b000;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(6'd6, a); chk("R13 mask after reset", a, 0);
        rd(6'd5, a); chk("R13 pending after reset", a, 0);
        rd(6'd20, a); chk("R13 route after reset", a, 0);
        chk("R13 pins after reset", 32'(irq_pin), 0);

        finish_run();
    end
endmodule